// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Line Control

This block turns parallel characters into asynchronous serial frames on a single output line. Each frame opens with a low start bit, carries 5 to 8 data bits with the least significant bit first, may add a parity bit, and closes with a high stop period of one, one and a half or two bit times. The character length, the parity mode and the stop length come from a set of line-control inputs. The shifter captures these inputs when it takes a character, so a frame that is already on the line keeps its format.

All bit timing counts pulses of an oversampling enable that runs at sixteen times the bit rate, and each bit lasts sixteen such pulses. A one-entry holding stage accepts a character through a valid/ready handshake while the shifter is still busy with the previous one, so characters can follow each other back to back. A break input pulls the line low for as long as it is held. The frame underneath keeps its timing while the line is held low. An empty output tells the surrounding logic when the holding stage is free and the last stop period has ended.

Top module: `sertx_line_ctl`

## Requirements
- R1: While reset is held and right after it is released, `txd` is 1, `tx_empty` is 1 and `in_ready` is 1.
- R2: `in_ready` is high exactly when the holding stage is free. A character is accepted on a clock edge where `in_valid` and `in_ready` are both high, and `in_ready` is low in the cycle that follows the acceptance.
- R3: A frame begins with a start bit at 0, followed by the data bits least significant first. `char_len` selects 5, 6, 7 or 8 data bits for the codes 0, 1, 2 and 3, and data bits above the selected length are not sent.
- R4: With `par_en`=0 no parity bit is sent. With `par_en`=1 a parity bit follows the data. With `par_odd`=0 the count of ones in the sent data bits plus the parity bit is even, and with `par_odd`=1 that count is odd.
- R5: The stop period is 1 and lasts 16 ticks when `stop_long`=0. With `stop_long`=1 it lasts 24 ticks for 5-bit characters and 32 ticks for 6 to 8 bits.
- R6: Frame timing advances only on clock edges where `tick16` is high. Every start, data and parity bit lasts 16 ticks.
- R7: From the cycle after `brk` rises until the cycle after it falls, `txd` is 0. A frame in progress keeps its timing, so the frame ends in the same cycle as it would without the break.
- R8: `tx_empty` is 1 only when no character is held and the shifter is idle. After a single character it rises in the cycle that ends the final stop tick.
- R9: A character held during a frame begins its start bit on the line 161 cycles after the previous start bit for an 8-bit frame with no parity and one stop bit, when `tick16` is high every cycle. `tx_empty` stays 0 between the two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Oversampling enable at 16x the bit rate |
| char_len | input | LEN_W (2) | Character length code, data bits = MIN_CHAR + code |
| par_en | input | 1 | Adds a parity bit when 1 |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| stop_long | input | 1 | 0 gives one stop bit, 1 gives 1.5 (shortest length) or 2 stop bits |
| brk | input | 1 | Holds the line low while 1 |
| in_data | input | DATA_W (8) | Character to send |
| in_valid | input | 1 | A character is offered on `in_data` |
| in_ready | output | 1 | The holding stage can accept a character |
| txd | output | 1 | Serial line, high when idle |
| tx_empty | output | 1 | Nothing held and shifter idle |

## Verification
A wrong tick count or a stale bit index shows up as a frame whose edges land off the expected 16-tick grid. The bench sees this within one bit time, at the mid-bit sampling point, and again as a wrong count of cycles to `tx_empty`. A wrong stop limit or parity mask does not show until the end of a frame, as a shifted `tx_empty` edge or a wrong parity level one bit before the stop period. A lost or duplicated handshake shows within a single cycle on `in_ready`. A break that gates the timing instead of only the output moves the end of the frame by as many cycles as the break was held.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

   // Phase of the frame currently on the line
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_START,
      PH_DATA,
      PH_PAR,
      PH_STOP
   } tx_phase_e;

   // Frame options captured with each character
   typedef struct packed {
      logic par_en;
      logic par_odd;
      logic stop_long;
   } frame_opt_t;

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   input  logic              take,
   output logic              hold_valid,
   output logic [DATA_W-1:0] hold_data
);

   logic              full_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         data_q <= '0;
      end else if (in_valid && !full_q) begin
         full_q <= 1'b1;
         data_q <= in_data;
      end else if (take) begin
         full_q <= 1'b0;
      end
   end

   assign in_ready   = !full_q;
   assign hold_valid = full_q;
   assign hold_data  = data_q;

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
   import sertx_pkg::*;
#(
   parameter int OVS      = 16,
   parameter int MIN_CHAR = 5,
   parameter int LEN_W    = 2,
   localparam int DATA_W  = MIN_CHAR + (1 << LEN_W) - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              ld_avail,
   input  logic [DATA_W-1:0] ld_data,
   input  logic [LEN_W-1:0]  len,
   input  frame_opt_t        opt,
   output logic              ld_take,
   output logic              line_bit,
   output logic              busy
);

   localparam int CNT_W = $clog2(2 * OVS);
   localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] ONE_M1  = CNT_W'(OVS - 1);
   localparam logic [CNT_W-1:0] HALF_M1 = CNT_W'(OVS + OVS / 2 - 1);
   localparam logic [CNT_W-1:0] TWO_M1  = CNT_W'(2 * OVS - 1);

   tx_phase_e         ph_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [IDX_W-1:0]  idx_q;
   logic [IDX_W-1:0]  last_q;
   logic [DATA_W-1:0] sh_q;
   logic              par_q;
   logic              pen_q;
   logic [CNT_W-1:0]  stop_m1_q;

   logic [DATA_W-1:0] len_mask;
   logic              par_calc;
   logic [CNT_W-1:0]  stop_m1_d;
   logic [IDX_W-1:0]  last_d;
   logic [CNT_W-1:0]  lim_m1;
   logic              wrap;

   // Mask of the data bits that the selected length sends
   always_comb begin
      for (int i = 0; i < DATA_W; i++) begin
         len_mask[i] = (i < MIN_CHAR + int'(len));
      end
   end

   assign par_calc = (^(ld_data & len_mask)) ^ opt.par_odd;
   assign last_d   = IDX_W'(MIN_CHAR - 1 + int'(len));

   always_comb begin
      if (!opt.stop_long)  stop_m1_d = ONE_M1;
      else if (len == '0)  stop_m1_d = HALF_M1;
      else                 stop_m1_d = TWO_M1;
   end

   assign ld_take = (ph_q == PH_IDLE) && ld_avail;
   assign lim_m1  = (ph_q == PH_STOP) ? stop_m1_q : ONE_M1;
   assign wrap    = (cnt_q == lim_m1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q      <= PH_IDLE;
         cnt_q     <= '0;
         idx_q     <= '0;
         last_q    <= '0;
         sh_q      <= '0;
         par_q     <= 1'b0;
         pen_q     <= 1'b0;
         stop_m1_q <= ONE_M1;
      end else if (ld_take) begin
         ph_q      <= PH_START;
         cnt_q     <= '0;
         idx_q     <= '0;
         last_q    <= last_d;
         sh_q      <= ld_data;
         par_q     <= par_calc;
         pen_q     <= opt.par_en;
         stop_m1_q <= stop_m1_d;
      end else if (ph_q != PH_IDLE && tick) begin
         if (!wrap) begin
            cnt_q <= cnt_q + CNT_W'(1);
         end else begin
            cnt_q <= '0;
            unique case (ph_q)
               PH_START: ph_q <= PH_DATA;
               PH_DATA: begin
                  sh_q <= sh_q >> 1;
                  if (idx_q == last_q) ph_q <= pen_q ? PH_PAR : PH_STOP;
                  else                 idx_q <= idx_q + IDX_W'(1);
               end
               PH_PAR:  ph_q <= PH_STOP;
               PH_STOP: ph_q <= PH_IDLE;
               default: ph_q <= PH_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      unique case (ph_q)
         PH_START: line_bit = 1'b0;
         PH_DATA:  line_bit = sh_q[0];
         PH_PAR:   line_bit = par_q;
         default:  line_bit = 1'b1;
      endcase
   end

   assign busy = (ph_q != PH_IDLE);

endmodule

// File: rtl/sertx_drive.sv
module sertx_drive #(
   parameter bit REG_OUT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic brk,
   input  logic line_bit,
   output logic txd
);

   generate
      if (REG_OUT) begin : g_reg
         logic txd_q;
         always_ff @(posedge clk) begin
            if (!rst_n) txd_q <= 1'b1;
            else        txd_q <= line_bit & ~brk;
         end
         assign txd = txd_q;
      end else begin : g_comb
         assign txd = line_bit & ~brk;
      end
   endgenerate

endmodule

// File: rtl/sertx_line_ctl.sv
module sertx_line_ctl
   import sertx_pkg::*;
#(
   parameter int OVS      = 16,
   parameter int MIN_CHAR = 5,
   parameter int LEN_W    = 2,
   parameter bit REG_OUT  = 1'b1,
   localparam int DATA_W  = MIN_CHAR + (1 << LEN_W) - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick16,
   input  logic [LEN_W-1:0]  char_len,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              stop_long,
   input  logic              brk,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_valid,
   output logic              in_ready,
   output logic              txd,
   output logic              tx_empty
);

   initial begin
      if (OVS < 4 || (OVS % 2) != 0)
         $fatal(1, "sertx_line_ctl: OVS must be even and at least 4");
      if (MIN_CHAR < 1 || LEN_W < 1)
         $fatal(1, "sertx_line_ctl: MIN_CHAR and LEN_W must be positive");
   end

   logic              hold_valid;
   logic [DATA_W-1:0] hold_data;
   logic              take;
   logic              line_bit;
   logic              busy;
   frame_opt_t        opt;

   assign opt.par_en    = par_en;
   assign opt.par_odd   = par_odd;
   assign opt.stop_long = stop_long;

   sertx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_data    (in_data),
      .in_ready   (in_ready),
      .take       (take),
      .hold_valid (hold_valid),
      .hold_data  (hold_data)
   );

   sertx_shift #(.OVS(OVS), .MIN_CHAR(MIN_CHAR), .LEN_W(LEN_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick16),
      .ld_avail (hold_valid),
      .ld_data  (hold_data),
      .len      (char_len),
      .opt      (opt),
      .ld_take  (take),
      .line_bit (line_bit),
      .busy     (busy)
   );

   sertx_drive #(.REG_OUT(REG_OUT)) u_drive (
      .clk      (clk),
      .rst_n    (rst_n),
      .brk      (brk),
      .line_bit (line_bit),
      .txd      (txd)
   );

   assign tx_empty = !hold_valid && !busy;

endmodule

// File: rtl/sertx_line_ctl_chk.sv
module sertx_line_ctl_chk (
   input logic clk,
   input logic rst_n,
   input logic tick16,
   input logic brk,
   input logic in_valid,
   input logic in_ready,
   input logic txd,
   input logic tx_empty
);

   // R2
   accept_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);

   // R7
   brk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brk |=> !txd);

   // R8
   empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty |-> in_ready);

   // R8
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_empty && !brk) |=> txd);

   // R6
   end_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_empty) |-> $past(tick16));

endmodule

bind sertx_line_ctl sertx_line_ctl_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick16   (tick16),
   .brk      (brk),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .txd      (txd),
   .tx_empty (tx_empty)
);

// File: tb/sim_sertx_line_ctl.sv
`timescale 1ns/1ps
module sim_sertx_line_ctl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b0;
   logic [1:0] char_len = 2'd3;
   logic       par_en = 1'b0;
   logic       par_odd = 1'b0;
   logic       stop_long = 1'b0;
   logic       brk = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic       txd;
   logic       tx_empty;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   bit slow = 1'b0;

   // {data[7:0], len[1:0], par_en, par_odd, stop_long}
   localparam logic [12:0] VECS [0:7] = '{
      {8'h55, 2'd3, 1'b0, 1'b0, 1'b0},
      {8'hA3, 2'd3, 1'b1, 1'b0, 1'b0},
      {8'hA3, 2'd3, 1'b1, 1'b1, 1'b1},
      {8'hFB, 2'd0, 1'b0, 1'b0, 1'b1},
      {8'hE6, 2'd0, 1'b1, 1'b1, 1'b1},
      {8'h2D, 2'd1, 1'b1, 1'b0, 1'b1},
      {8'h7F, 2'd2, 1'b1, 1'b1, 1'b0},
      {8'h80, 2'd2, 1'b1, 1'b0, 1'b1}
   };

   sertx_line_ctl u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick16    (tick16),
      .char_len  (char_len),
      .par_en    (par_en),
      .par_odd   (par_odd),
      .stop_long (stop_long),
      .brk       (brk),
      .in_data   (in_data),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .txd       (txd),
      .tx_empty  (tx_empty)
   );

   always #10 clk = ~clk;

   // Tick source: every cycle, or one cycle in three when slow is set
   initial begin
      int ph = 0;
      forever begin
         @(negedge clk);
         if (slow) begin
            tick16 = (ph == 0);
            ph = (ph == 2) ? 0 : ph + 1;
         end else begin
            tick16 = 1'b1;
            ph = 0;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   // Called just after a negedge; returns at the negedge after acceptance
   task automatic send(input logic [7:0] d);
      in_data  = d;
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic wait_fall();
      while (txd !== 1'b0) @(negedge clk);
   endtask

   task automatic run_frame(input logic [12:0] v);
      int n, p, ones, parb, stop_t, total, k;
      logic [7:0] d;
      d         = v[12:5];
      char_len  = v[4:3];
      par_en    = v[2];
      par_odd   = v[1];
      stop_long = v[0];
      n = 5 + int'(v[4:3]);
      p = v[2] ? 1 : 0;
      ones = 0;
      for (int i = 0; i < n; i++) ones += d[i];
      parb = (ones % 2) ^ (v[1] ? 1 : 0);
      stop_t = !v[0] ? 16 : ((n == 5) ? 24 : 32);
      total = 16 * (1 + n + p) + stop_t;
      send(d);
      wait_fall();
      k = 0;
      while (tx_empty !== 1'b1 && k < 4000) begin
         if (k == 8) chk(txd == 1'b0, "R3", "start bit", txd, 0);
         for (int i = 0; i < n; i++)
            if (k == 8 + 16 * (i + 1))
               chk(txd == d[i], "R3", $sformatf("data bit %0d", i), txd, d[i]);
         if (p == 1 && k == 8 + 16 * (n + 1))
            chk(txd == parb[0], "R4", "parity bit", txd, parb);
         if (k == 8 + 16 * (n + 1 + p))
            chk(txd == 1'b1, "R5", "stop level", txd, 1);
         @(negedge clk);
         k++;
      end
      chk(k == total - 1, "R5", "cycles to empty (R8)", k, total - 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      int k;
      bit seen_empty;
      repeat (4) @(negedge clk);
      // R1 during reset
      chk(txd == 1'b1, "R1", "txd in reset", txd, 1);
      chk(tx_empty == 1'b1, "R1", "empty in reset", tx_empty, 1);
      chk(in_ready == 1'b1, "R1", "ready in reset", in_ready, 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(txd == 1'b1, "R1", "txd after reset", txd, 1);
      chk(tx_empty == 1'b1, "R1", "empty after reset", tx_empty, 1);
      chk(in_ready == 1'b1, "R1", "ready after reset", in_ready, 1);

      // Vector table: R3, R4, R5 over all lengths, parities and stop modes
      foreach (VECS[i]) begin
         run_frame(VECS[i]);
         repeat (3) @(negedge clk);
      end

      // R2 / R9: back-to-back characters, 8N1
      char_len = 2'd3; par_en = 1'b0; stop_long = 1'b0;
      send(8'h00);
      chk(in_ready == 1'b0, "R2", "ready after accept", in_ready, 0);
      chk(tx_empty == 1'b0, "R8", "empty while held", tx_empty, 0);
      send(8'h3C);
      chk(txd == 1'b0, "R9", "first start bit", txd, 0);
      k = 0;
      seen_empty = 1'b0;
      while (txd == 1'b0 && k < 400) begin
         if (k == 50) chk(in_ready == 1'b0, "R2", "ready while second held", in_ready, 0);
         @(negedge clk); k++;
      end
      while (txd == 1'b1 && k < 400) begin
         if (tx_empty) seen_empty = 1'b1;
         @(negedge clk); k++;
      end
      chk(k == 161, "R9", "start-to-start cycles", k, 161);
      chk(!seen_empty, "R9", "empty between frames", seen_empty, 0);
      while (tx_empty !== 1'b1 && k < 1000) begin
         @(negedge clk); k++;
      end
      chk(k == 320, "R8", "second frame end", k, 320);
      repeat (3) @(negedge clk);

      // R7: break during a frame
      send(8'hFF);
      wait_fall();
      repeat (40) @(negedge clk);
      brk = 1'b1;
      @(negedge clk);
      chk(txd == 1'b0, "R7", "break forces low", txd, 0);
      repeat (29) @(negedge clk);
      chk(txd == 1'b0, "R7", "break held low", txd, 0);
      brk = 1'b0;
      @(negedge clk);
      chk(txd == 1'b1, "R7", "line restored", txd, 1);
      k = 71;
      while (tx_empty !== 1'b1 && k < 1000) begin
         @(negedge clk); k++;
      end
      chk(k == 159, "R7", "frame timing under break", k, 159);

      // R7: break while idle
      @(negedge clk);
      brk = 1'b1;
      @(negedge clk);
      chk(txd == 1'b0, "R7", "idle break low", txd, 0);
      chk(tx_empty == 1'b1, "R7", "idle break keeps empty", tx_empty, 1);
      repeat (5) @(negedge clk);
      brk = 1'b0;
      @(negedge clk);
      chk(txd == 1'b1, "R7", "idle break release", txd, 1);

      // R6: sparse ticks stretch the bit
      slow = 1'b1;
      repeat (3) @(negedge clk);
      send(8'h01);
      wait_fall();
      k = 0;
      while (txd == 1'b0 && k < 200) begin
         @(negedge clk); k++;
      end
      chk(k >= 46 && k <= 48, "R6", "start bit cycles at 1/3 tick rate", k, 48);
      while (tx_empty !== 1'b1) @(negedge clk);
      slow = 1'b0;
      repeat (3) @(negedge clk);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule